// File: doc/BRIEF.md
# Carry-Less Quadword Multiplier

This block multiplies two binary polynomials whose coefficients lie in GF(2). Each operand is a 128-bit source register. A small immediate field picks the low or the high 64-bit quadword of each source. The two picked quadwords are multiplied as polynomials. Partial products are combined with exclusive OR, so no carry ever moves between bit positions. The full unreduced 128-bit product is returned. Any reduction modulo an irreducible polynomial is left to later logic.

The multiply is bit-serial. It takes one multiplier bit per clock and spends a fixed 64 cycles per product. A second, single-cycle operation returns the bitwise XOR of both full 128-bit sources; this is field addition. A caller pulses `start_i` with the operation code and the operands. It then waits for the one-cycle `done_o` pulse, and reads `result_o`, which holds its value until the next accepted start.

Top module: `clmul_unit`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `busy_o` is 0, `done_o` is 0 and `result_o` is all zeros.
- R2: A multiply (`op_i`=0) accepted on a clock edge gives `done_o`=1 in exactly the cycle that follows the 64th later edge. At that point `result_o` equals the carry-less product of the two selected quadwords: the XOR of (A shifted left by i) over every set bit i of B.
- R3: Immediate bit 0 picks the quadword of source 1 and immediate bit 4 picks the quadword of source 2. A bit value of 1 picks bits [127:64] and a value of 0 picks bits [63:0]. All other immediate bits have no effect.
- R4: An XOR operation (`op_i`=1) accepted on an edge gives `done_o`=1 in the very next cycle, with `result_o` = `src1_i` ^ `src2_i` over all 128 bits. `busy_o` stays 0 throughout.
- R5: A start pulse that arrives while `busy_o` is 1 is ignored. The running multiply completes on its original schedule with its original operands.
- R6: Bit 127 of every multiply result is 0.
- R7: `done_o` is high for a single cycle. `result_o` changes only in a cycle where `done_o` is high and otherwise keeps its value.
- R8: `busy_o` is 1 from the cycle after an accepted multiply start until the cycle in which `done_o` rises. `busy_o` and `done_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request pulse; taken only when not busy |
| op_i | input | 1 | 0 = carry-less multiply, 1 = 128-bit XOR |
| imm_i | input | 8 | Quadword select: bit 0 for source 1, bit 4 for source 2 |
| src1_i | input | 128 | First source register |
| src2_i | input | 128 | Second source register |
| busy_o | output | 1 | Multiply in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 128 | Product or sum, held until the next accepted start |

## Verification
Each multiply pattern is chosen to expose a different kind of fault:
- A constant-one multiplier and a zero operand show whether shift alignment and clearing are correct.
- All-ones quadwords put a 1 on the highest possible product bit. Any carry leaking between positions, or a wrong accumulation order, changes many bits at once.
- Sparse single-bit and mixed constants expose shifts that are off by one position.
- Sources with distinct low and high halves, run under all four quadword selections and under immediates with unrelated bits set, show which half each select bit reaches.
- A second start sent mid-run, and an XOR request, show that the engine ignores requests while busy, and show the single-cycle addition path together with its timing.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

    typedef enum logic {
        OP_CLMUL = 1'b0,
        OP_XOR   = 1'b1
    } clmul_op_e;

    localparam int IMM_W        = 8;
    localparam int IMM_SRC1_BIT = 0;
    localparam int IMM_SRC2_BIT = 4;

    typedef struct packed {
        logic hi_a;
        logic hi_b;
    } qsel_t;

    function automatic qsel_t decode_imm(input logic [IMM_W-1:0] imm);
        qsel_t s;
        s.hi_a = imm[IMM_SRC1_BIT];
        s.hi_b = imm[IMM_SRC2_BIT];
        return s;
    endfunction

endpackage

// File: rtl/clmul_qword_sel.sv
module clmul_qword_sel #(
    parameter int QW = 64
) (
    input  logic [2*QW-1:0] src_i,
    input  logic            hi_i,
    output logic [QW-1:0]   qw_o
);
    always_comb begin
        qw_o = hi_i ? src_i[2*QW-1:QW] : src_i[QW-1:0];
    end
endmodule

// File: rtl/gf2_add.sv
module gf2_add #(
    parameter int W = 128
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] sum_o
);
    always_comb begin
        sum_o = a_i ^ b_i;
    end
endmodule

// File: rtl/clmul_serial_engine.sv
module clmul_serial_engine #(
    parameter int QW = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load_i,
    input  logic [QW-1:0]   mcand_i,
    input  logic [QW-1:0]   mplier_i,
    output logic            busy_o,
    output logic            fin_o,
    output logic [2*QW-1:0] prod_o
);
    localparam int PW = 2 * QW;
    localparam int CW = (QW > 1) ? $clog2(QW) : 1;
    localparam logic [CW-1:0] LAST = CW'(QW - 1);

    logic [PW-1:0] acc_q;
    logic [QW-1:0] mcand_q;
    logic [QW-1:0] mplier_q;
    logic [CW-1:0] cnt_q;
    logic          busy_q;
    logic [PW-1:0] acc_nxt;

    // MSB-first Horner step: shift accumulator, fold in multiplicand if bit set
    always_comb begin
        acc_nxt = {acc_q[PW-2:0], 1'b0};
        if (mplier_q[QW-1]) begin
            acc_nxt = acc_nxt ^ {{QW{1'b0}}, mcand_q};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            mcand_q  <= '0;
            mplier_q <= '0;
            cnt_q    <= '0;
            busy_q   <= 1'b0;
        end else if (busy_q) begin
            acc_q    <= acc_nxt;
            mplier_q <= {mplier_q[QW-2:0], 1'b0};
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (load_i) begin
            acc_q    <= '0;
            mcand_q  <= mcand_i;
            mplier_q <= mplier_i;
            cnt_q    <= '0;
            busy_q   <= 1'b1;
        end
    end

    assign busy_o = busy_q;
    assign fin_o  = busy_q && (cnt_q == LAST);
    assign prod_o = acc_nxt;
endmodule

// File: rtl/clmul_unit.sv
module clmul_unit
    import clmul_pkg::*;
#(
    parameter int QW = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic                  op_i,
    input  logic [7:0]            imm_i,
    input  logic [2*QW-1:0]       src1_i,
    input  logic [2*QW-1:0]       src2_i,
    output logic                  busy_o,
    output logic                  done_o,
    output logic [2*QW-1:0]       result_o
);
    localparam int SW = 2 * QW;
    localparam int NSRC = 2;

    qsel_t     qsel;
    clmul_op_e op;
    logic      accept;
    logic      eng_busy;
    logic      eng_fin;
    logic [SW-1:0] eng_prod;
    logic [SW-1:0] xor_sum;

    logic [NSRC-1:0][SW-1:0] src_arr;
    logic [NSRC-1:0]         hi_arr;
    logic [NSRC-1:0][QW-1:0] qw_arr;

    assign qsel       = decode_imm(imm_i);
    assign op         = clmul_op_e'(op_i);
    assign src_arr[0] = src1_i;
    assign src_arr[1] = src2_i;
    assign hi_arr[0]  = qsel.hi_a;
    assign hi_arr[1]  = qsel.hi_b;

    for (genvar g = 0; g < NSRC; g++) begin : g_sel
        clmul_qword_sel #(.QW(QW)) u_sel (
            .src_i (src_arr[g]),
            .hi_i  (hi_arr[g]),
            .qw_o  (qw_arr[g])
        );
    end

    assign accept = start_i && !eng_busy;

    clmul_serial_engine #(.QW(QW)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .load_i   (accept && (op == OP_CLMUL)),
        .mcand_i  (qw_arr[0]),
        .mplier_i (qw_arr[1]),
        .busy_o   (eng_busy),
        .fin_o    (eng_fin),
        .prod_o   (eng_prod)
    );

    gf2_add #(.W(SW)) u_add (
        .a_i   (src1_i),
        .b_i   (src2_i),
        .sum_o (xor_sum)
    );

    logic [SW-1:0] res_q;
    logic          done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept && (op == OP_XOR)) begin
                res_q  <= xor_sum;
                done_q <= 1'b1;
            end else if (eng_fin) begin
                res_q  <= eng_prod;
                done_q <= 1'b1;
            end
        end
    end

    assign busy_o   = eng_busy;
    assign done_o   = done_q;
    assign result_o = res_q;
endmodule

// File: rtl/clmul_unit_chk.sv
module clmul_unit_chk #(
    parameter int QW = 64
) (
    input logic            clk,
    input logic            rst,
    input logic            start_i,
    input logic            op_i,
    input logic            busy_o,
    input logic            done_o,
    input logic [2*QW-1:0] result_o
);
    logic last_mul;

    always_ff @(posedge clk) begin
        if (rst) last_mul <= 1'b0;
        else if (start_i && !busy_o) last_mul <= !op_i;
    end

    a_r8_busy_after_mul_start: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && !op_i) |=> busy_o);

    a_r8_busy_done_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));

    a_r2_done_when_busy_ends: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o);

    a_r4_xor_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && op_i) |=> (done_o && !busy_o));

    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r7_result_held: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(result_o));

    a_r6_top_bit_zero: assert property (@(posedge clk) disable iff (rst)
        (done_o && last_mul) |-> !result_o[2*QW-1]);
endmodule

bind clmul_unit clmul_unit_chk #(.QW(QW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .op_i     (op_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o)
);

// File: tb/clmul_unit_bench.sv
`timescale 1ns/1ps
module clmul_unit_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         op_i = 1'b0;
    logic [7:0]   imm_i = 8'h00;
    logic [127:0] src1_i = '0;
    logic [127:0] src2_i = '0;
    logic         busy_o;
    logic         done_o;
    logic [127:0] result_o;

    always #2.5 clk = ~clk;

    clmul_unit u_clmul_unit (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .imm_i(imm_i),
        .src1_i(src1_i), .src2_i(src2_i), .busy_o(busy_o), .done_o(done_o),
        .result_o(result_o)
    );

    int    n_chk = 0;
    int    n_err = 0;
    string cur_req = "R1";
    bit    armed = 1'b0;

    task automatic check(input bit ok, input string req,
                         input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [127:0] ref_clmul(input logic [63:0] a, input logic [63:0] b);
        logic [127:0] r = '0;
        for (int i = 0; i < 64; i++)
            if (b[i]) r = r ^ ({64'b0, a} << i);
        return r;
    endfunction

    function automatic logic [63:0] pick(input logic [127:0] s, input logic hi);
        return hi ? s[127:64] : s[63:0];
    endfunction

    // behavioural reference model, advanced on every rising edge
    bit           m_busy = 0, m_done = 0;
    int           m_cnt = 0;
    logic [127:0] m_res = '0, m_pend = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_done = 0; m_cnt = 0; m_res = '0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == 64) begin
                    m_busy = 0; m_done = 1; m_res = m_pend;
                end
            end else if (start_i) begin
                if (op_i) begin
                    m_res = src1_i ^ src2_i; m_done = 1;
                end else begin
                    m_busy = 1; m_cnt = 0;
                    m_pend = ref_clmul(pick(src1_i, imm_i[0]), pick(src2_i, imm_i[4]));
                end
            end
        end
    end

    // per-clock comparison, away from the rising edge
    always @(negedge clk) begin
        if (armed && !rst) begin
            check(busy_o == m_busy, "R8", {127'b0, busy_o}, {127'b0, m_busy});
            check(done_o == m_done, cur_req, {127'b0, done_o}, {127'b0, m_done});
            check(result_o == m_res, cur_req, result_o, m_res);
        end
    end

    task automatic run_op(input bit op, input logic [7:0] imm,
                          input logic [127:0] a, input logic [127:0] b, input string req);
        logic [127:0] exp;
        bit got = 0;
        @(negedge clk);
        cur_req = req;
        op_i = op; imm_i = imm; src1_i = a; src2_i = b; start_i = 1'b1;
        exp = op ? (a ^ b) : ref_clmul(pick(a, imm[0]), pick(b, imm[4]));
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (done_o) begin got = 1; break; end
        end
        check(got, req, {127'b0, got}, 128'd1);
        check(result_o == exp, req, result_o, exp);
        if (!op) check(result_o[127] == 1'b0, "R6", {127'b0, result_o[127]}, '0);
        repeat (2) @(negedge clk);
    endtask

    localparam logic [127:0] SA = 128'hF0E1D2C3B4A59687_0123456789ABCDEF;
    localparam logic [127:0] SB = 128'h8000000000000001_13579BDF2468ACE0;

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1 reset state while in reset
        check(busy_o == 0, "R1", {127'b0, busy_o}, '0);
        check(done_o == 0, "R1", {127'b0, done_o}, '0);
        check(result_o == '0, "R1", result_o, '0);
        rst = 1'b0;
        armed = 1'b1;
        @(negedge clk);
        check(result_o == '0 && !busy_o && !done_o, "R1", result_o, '0);

        // R2 main multiply patterns
        run_op(0, 8'h00, {64'h0, 64'hDEADBEEFCAFEF00D}, 128'd1, "R2");
        run_op(0, 8'h00, {64'h0, 64'h1234}, 128'd0, "R2");
        run_op(0, 8'h00, {64'h0, {64{1'b1}}}, {64'h0, {64{1'b1}}}, "R2");
        run_op(0, 8'h00, {64'h0, 64'h8000000000000000}, {64'h0, 64'h8000000000000000}, "R2");
        run_op(0, 8'h00, {64'h0, 64'h0000000000000003}, {64'h0, 64'h0000000000000003}, "R2");
        run_op(0, 8'h00, SA, SB, "R2");

        // R3 quadword selection, including unrelated immediate bits
        run_op(0, 8'h00, SA, SB, "R3");
        run_op(0, 8'h01, SA, SB, "R3");
        run_op(0, 8'h10, SA, SB, "R3");
        run_op(0, 8'h11, SA, SB, "R3");
        run_op(0, 8'hEE, SA, SB, "R3");
        run_op(0, 8'hEF, SB, SA, "R3");

        // R4 field addition
        run_op(1, 8'h11, SA, SB, "R4");
        run_op(1, 8'h00, {128{1'b1}}, SA, "R4");

        // R5 start while busy is ignored
        begin
            logic [127:0] exp5;
            bit got5 = 0;
            @(negedge clk);
            cur_req = "R5";
            op_i = 0; imm_i = 8'h01; src1_i = SA; src2_i = SB; start_i = 1;
            exp5 = ref_clmul(SA[127:64], SB[63:0]);
            @(negedge clk); start_i = 0;
            repeat (5) @(negedge clk);
            op_i = 1; imm_i = 8'h10; src1_i = SB; src2_i = {128{1'b1}}; start_i = 1;
            @(negedge clk);
            op_i = 0; start_i = 1;
            @(negedge clk); start_i = 0;
            check(!done_o && busy_o, "R5", {126'b0, busy_o, done_o}, 128'd2);
            for (int i = 0; i < 80; i++) begin
                @(negedge clk);
                if (done_o) begin got5 = 1; break; end
            end
            check(got5 && result_o == exp5, "R5", result_o, exp5);
            repeat (2) @(negedge clk);
        end

        // R7 result held while inputs change with no start
        cur_req = "R7";
        begin
            logic [127:0] held;
            held = result_o;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                src1_i = src1_i ^ 128'h5A5A; imm_i = imm_i + 8'd3;
                check(result_o == held && !done_o, "R7", result_o, held);
            end
        end

        armed = 1'b0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule